// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with 10/11-bit Framing

This block sends characters on a single serial output, one at a time. A write strobe on the data input starts a frame when the block is idle. The block puts a low start bit in front of the character and a high stop bit after it. It holds every bit for a fixed number of ticks of an external timing pulse that runs at a multiple of the baud rate. A strap input selects the frame length: a 10-bit frame carries eight payload bits, and an 11-bit frame carries eight data bits followed by a ninth bit. The ninth bit is held in a sticky register. Software can load it, and a received character can also overwrite it. In the 10-bit frame the block can replace the top data bit with an even-parity bit that it computes itself.

While a frame is being sent, the block raises an output enable that hands the pin to the transmitter. When no frame is being sent, the pin carries the general-purpose port value. When the last stop bit ends, a transmit-complete flag is set. That flag drives an interrupt output through an enable. Software can clear the flag, or set it to raise an interrupt on purpose. The next accepted character also clears it.

Top module: `ser_tx_frame`

## Requirements
- R1: After reset, uart_oe, tx_done, bit9_q and irq are 0.
- R2: When dat_wr is high while uart_oe is low, uart_oe is high after that clock edge and txd is 0 (start bit). Every frame bit is held for exactly TICKS_PER_BIT (default 8) clock cycles on which baud_tick is high.
- R3: Frame bit 0 is the start bit (0). Payload bits follow, least significant first. With frame11=0 the frame is 10 bits: start, 8 payload bits, one stop bit (1). With frame11=1 the frame is 11 bits: start, dat_wdata[7:0], bit9_q, one stop bit (1).
- R4: With frame11=0 and par_en=1, payload bits 0..6 are dat_wdata[6:0] and payload bit 7 is the XOR of dat_wdata[6:0] (even parity), so dat_wdata[7] is not sent. With frame11=1, par_en has no effect.
- R5: A ctl_wr loads ctl_b9_wdata into bit9_q. Otherwise rx_b9_load loads rx_b9_value; ctl_wr wins when both are high. In all other cases bit9_q keeps its value across any number of frames.
- R6: uart_oe stays high for the whole frame, stop bit included. While uart_oe is low, txd equals port_dout.
- R7: tx_done becomes 1 on the same clock edge that ends the stop bit and drops uart_oe.
- R8: A ctl_wr with ctl_done_wdata=0 clears tx_done. A dat_wr that starts a frame also clears tx_done. If ctl_wr is high in the same cycle, the value written by ctl_wr wins.
- R9: A ctl_wr with ctl_done_wdata=1 sets tx_done without starting a frame (uart_oe stays 0).
- R10: irq is high exactly when both tx_done and irq_en are high.
- R11: A dat_wr while uart_oe is high is ignored. The current frame goes on unchanged, and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at TICKS_PER_BIT times the baud rate |
| frame11 | input | 1 | Frame length strap: 1 = 11-bit, 0 = 10-bit |
| par_en | input | 1 | Automatic even parity in the 10-bit frame |
| irq_en | input | 1 | Interrupt enable |
| dat_wr | input | 1 | Data write strobe |
| dat_wdata | input | DATA_W | Character to send |
| ctl_wr | input | 1 | Control write strobe |
| ctl_done_wdata | input | 1 | Value written to the transmit-complete flag |
| ctl_b9_wdata | input | 1 | Value written to the ninth-bit register |
| rx_b9_load | input | 1 | Receiver strobe that overwrites the ninth bit |
| rx_b9_value | input | 1 | Ninth bit of the received character |
| port_dout | input | 1 | Port data driven on the pin when the transmitter is idle |
| txd | output | 1 | Serial pin output |
| uart_oe | output | 1 | Pin handed to the transmitter (frame in progress) |
| tx_done | output | 1 | Transmit-complete flag |
| bit9_q | output | 1 | Sticky ninth-bit register |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. baud_tick is a single-cycle pulse, frame11 changes only while no frame is in progress, and control writes are the only source of same-cycle conflicts with the hardware setting or clearing of the flag. The properties on the flag leave out cycles that follow a control write. The stimulus writes the control register and changes the strap only when idle, and it drives the tick as a pulse every fourth cycle. A scoreboard compares each frame bit at its middle tick and the frame length in ticks against expected frames built from the requirements.

// File: rtl/ser_tx_frame_pkg.sv
package ser_tx_frame_pkg;

   // Even parity over a vector: the returned bit makes the total count of ones even.
   function automatic logic even_bit(input logic [31:0] v, input int n);
      logic p;
      p = 1'b0;
      for (int i = 0; i < 32; i++) begin
         if (i < n) p = p ^ v[i];
      end
      return p;
   endfunction

   typedef enum logic {
      SER_IDLE = 1'b0,
      SER_SEND = 1'b1
   } ser_state_e;

endpackage

// File: rtl/ser_tx_flags.sv
module ser_tx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr,
   input  logic ctl_done_wdata,
   input  logic ctl_b9_wdata,
   input  logic rx_b9_load,
   input  logic rx_b9_value,
   input  logic accept,
   input  logic frame_end,
   input  logic irq_en,
   output logic done_q,
   output logic b9_q,
   output logic irq
);

   // Transmit-complete flag: software write > end of frame > start of frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else if (ctl_wr) begin
         done_q <= ctl_done_wdata;
      end else if (frame_end) begin
         done_q <= 1'b1;
      end else if (accept) begin
         done_q <= 1'b0;
      end
   end

   // Sticky ninth bit: software write beats the receiver update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b9_q <= 1'b0;
      end else if (ctl_wr) begin
         b9_q <= ctl_b9_wdata;
      end else if (rx_b9_load) begin
         b9_q <= rx_b9_value;
      end
   end

   assign irq = done_q & irq_en;

   // R5: without a write from either side the ninth bit holds
   p_b9_sticky_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_wr && !rx_b9_load) |=> $stable(b9_q))
      else $error("bit9 changed without a write");

endmodule

// File: rtl/ser_tx_build.sv
module ser_tx_build
   import ser_tx_frame_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int STOP_BITS = 1,
   localparam int FMAX     = DATA_W + 2 + STOP_BITS
) (
   input  logic [DATA_W-1:0] data,
   input  logic              b9,
   input  logic              long_frm,
   input  logic              par_en,
   output logic [FMAX-1:0]   frame
);

   logic [DATA_W-1:0] payload;
   logic              mid_bit;
   logic              par_bit;

   assign par_bit = even_bit(32'(data[DATA_W-2:0]), DATA_W - 1);

   // Parity only replaces the top data bit in the short frame
   always_comb begin
      if (!long_frm && par_en) begin
         payload = {par_bit, data[DATA_W-2:0]};
      end else begin
         payload = data;
      end
   end

   // Short frame: this slot is the stop bit; long frame: the ninth bit
   assign mid_bit = long_frm ? b9 : 1'b1;

   assign frame = {{STOP_BITS{1'b1}}, mid_bit, payload, 1'b0};

endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
   import ser_tx_frame_pkg::*;
#(
   parameter int FMAX          = 11,
   parameter int TICKS_PER_BIT = 8,
   localparam int TCW          = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1,
   localparam int BCW          = $clog2(FMAX)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            baud_tick,
   input  logic            load,
   input  logic            long_frm,
   input  logic [FMAX-1:0] frame_in,
   output logic            busy,
   output logic            ser_bit,
   output logic            accept,
   output logic            frame_end
);

   localparam logic [TCW-1:0] TICK_LAST  = TCW'(TICKS_PER_BIT - 1);
   localparam logic [BCW-1:0] LAST_LONG  = BCW'(FMAX - 1);
   localparam logic [BCW-1:0] LAST_SHORT = BCW'(FMAX - 2);

   ser_state_e       state;
   logic [FMAX-1:0]  shreg;
   logic [TCW-1:0]   tick_cnt;
   logic [BCW-1:0]   bit_cnt;
   logic             long_q;
   logic [BCW-1:0]   last_bit;
   logic             bit_end;

   assign busy      = (state == SER_SEND);
   assign accept    = load && !busy;
   assign last_bit  = long_q ? LAST_LONG : LAST_SHORT;
   assign bit_end   = busy && baud_tick && (tick_cnt == TICK_LAST);
   assign frame_end = bit_end && (bit_cnt == last_bit);
   assign ser_bit   = shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SER_IDLE;
         shreg    <= '1;
         tick_cnt <= '0;
         bit_cnt  <= '0;
         long_q   <= 1'b0;
      end else if (accept) begin
         state    <= SER_SEND;
         shreg    <= frame_in;
         tick_cnt <= '0;
         bit_cnt  <= '0;
         long_q   <= long_frm;
      end else if (busy && baud_tick) begin
         if (tick_cnt == TICK_LAST) begin
            tick_cnt <= '0;
            shreg    <= {1'b1, shreg[FMAX-1:1]};
            if (frame_end) begin
               state   <= SER_IDLE;
               bit_cnt <= '0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end else begin
            tick_cnt <= tick_cnt + 1'b1;
         end
      end
   end

   // R3: the bit index never passes the longest frame
   p_bitcnt_range_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bit_cnt <= LAST_LONG))
      else $error("bit counter past frame end");

   // R2: without a tick the current bit and its position stay put
   p_bit_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !baud_tick && !accept) |=> ($stable(shreg) && $stable(bit_cnt)))
      else $error("bit advanced without a tick");

   // R11: a write during a frame neither restarts nor ends it
   p_busy_write_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && load && !frame_end) |=> (busy && (bit_cnt >= $past(bit_cnt))))
      else $error("frame disturbed by a write");

endmodule

// File: rtl/ser_tx_frame.sv
module ser_tx_frame #(
   parameter int DATA_W        = 8,
   parameter int TICKS_PER_BIT = 8,
   parameter int STOP_BITS     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              frame11,
   input  logic              par_en,
   input  logic              irq_en,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] dat_wdata,
   input  logic              ctl_wr,
   input  logic              ctl_done_wdata,
   input  logic              ctl_b9_wdata,
   input  logic              rx_b9_load,
   input  logic              rx_b9_value,
   input  logic              port_dout,
   output logic              txd,
   output logic              uart_oe,
   output logic              tx_done,
   output logic              bit9_q,
   output logic              irq
);

   localparam int FMAX = DATA_W + 2 + STOP_BITS;

   generate
      if (DATA_W < 2 || DATA_W > 31) begin : g_bad_width
         $error("DATA_W must be within 2..31");
      end
      if (TICKS_PER_BIT < 2) begin : g_bad_ticks
         $error("TICKS_PER_BIT must be at least 2");
      end
      if (STOP_BITS < 1) begin : g_bad_stop
         $error("STOP_BITS must be at least 1");
      end
   endgenerate

   logic [FMAX-1:0] frame_w;
   logic            busy;
   logic            ser_bit;
   logic            accept;
   logic            frame_end;

   ser_tx_build #(
      .DATA_W    (DATA_W),
      .STOP_BITS (STOP_BITS)
   ) u_build (
      .data     (dat_wdata),
      .b9       (bit9_q),
      .long_frm (frame11),
      .par_en   (par_en),
      .frame    (frame_w)
   );

   ser_tx_shift #(
      .FMAX          (FMAX),
      .TICKS_PER_BIT (TICKS_PER_BIT)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .load      (dat_wr),
      .long_frm  (frame11),
      .frame_in  (frame_w),
      .busy      (busy),
      .ser_bit   (ser_bit),
      .accept    (accept),
      .frame_end (frame_end)
   );

   ser_tx_flags u_flags (
      .clk            (clk),
      .rst_n          (rst_n),
      .ctl_wr         (ctl_wr),
      .ctl_done_wdata (ctl_done_wdata),
      .ctl_b9_wdata   (ctl_b9_wdata),
      .rx_b9_load     (rx_b9_load),
      .rx_b9_value    (rx_b9_value),
      .accept         (accept),
      .frame_end      (frame_end),
      .irq_en         (irq_en),
      .done_q         (tx_done),
      .b9_q           (bit9_q),
      .irq            (irq)
   );

   // Pin multiplexer: the transmitter owns the pin only during a frame
   assign uart_oe = busy;
   assign txd     = uart_oe ? ser_bit : port_dout;

   // R2: a frame opens with a low start bit
   p_start_low_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uart_oe) |-> !txd)
      else $error("frame did not open with a start bit");

   // R7: the flag is set on the edge that releases the pin
   p_done_at_end_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(uart_oe) && !$past(ctl_wr)) |-> tx_done)
      else $error("flag not set at end of frame");

   // R8: starting a frame clears the flag
   p_clear_on_start_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(uart_oe) && !$past(ctl_wr)) |-> !tx_done)
      else $error("flag not cleared at frame start");

   // R9: a software set raises the flag without a frame
   p_soft_set_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_done_wdata && !uart_oe && !dat_wr) |=> (tx_done && !uart_oe))
      else $error("software set misbehaved");

endmodule

// File: tb/ser_tx_frame_tb.sv
module ser_tx_frame_tb;

   localparam int TPB = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       frame11 = 1'b0;
   logic       par_en = 1'b0;
   logic       irq_en = 1'b0;
   logic       dat_wr = 1'b0;
   logic [7:0] dat_wdata = '0;
   logic       ctl_wr = 1'b0;
   logic       ctl_done_wdata = 1'b0;
   logic       ctl_b9_wdata = 1'b0;
   logic       rx_b9_load = 1'b0;
   logic       rx_b9_value = 1'b0;
   logic       port_dout = 1'b1;
   logic       txd, uart_oe, tx_done, bit9_q, irq;

   ser_tx_frame u_dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .frame11(frame11),
      .par_en(par_en), .irq_en(irq_en), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
      .ctl_wr(ctl_wr), .ctl_done_wdata(ctl_done_wdata), .ctl_b9_wdata(ctl_b9_wdata),
      .rx_b9_load(rx_b9_load), .rx_b9_value(rx_b9_value), .port_dout(port_dout),
      .txd(txd), .uart_oe(uart_oe), .tx_done(tx_done), .bit9_q(bit9_q), .irq(irq)
   );

   always #5 clk = ~clk;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [15:0] bits;
      int          len;
   } exp_t;

   exp_t exp_q[$];
   logic b9_model = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // Tick pulse every fourth cycle, driven away from the edge
   int cyc = 0;
   always @(posedge clk) begin
      #1;
      baud_tick = (cyc % 4 == 0);
      cyc++;
   end

   function automatic exp_t make_frame(input logic [7:0] d, input logic lng,
                                       input logic par, input logic b9);
      exp_t e;
      logic [7:0] pay;
      pay = (!lng && par) ? {^d[6:0], d[6:0]} : d;
      e.bits = '0;
      e.bits[0] = 1'b0;
      e.bits[8:1] = pay;
      if (lng) begin
         e.bits[9]  = b9;
         e.bits[10] = 1'b1;
         e.len = 11;
      end else begin
         e.bits[9] = 1'b1;
         e.len = 10;
      end
      return e;
   endfunction

   // Driver: push the expected frame, then pulse the write strobe
   task automatic send_char(input logic [7:0] d);
      @(posedge clk); #1;
      exp_q.push_back(make_frame(d, frame11, par_en, b9_model));
      dat_wr = 1'b1;
      dat_wdata = d;
      @(posedge clk); #1;
      dat_wr = 1'b0;
   endtask

   task automatic ctl_write(input logic done_v, input logic b9_v);
      @(posedge clk); #1;
      ctl_wr = 1'b1;
      ctl_done_wdata = done_v;
      ctl_b9_wdata = b9_v;
      b9_model = b9_v;
      @(posedge clk); #1;
      ctl_wr = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (uart_oe) @(negedge clk);
   endtask

   // Monitor: compare each bit at its middle tick, and the frame length in ticks
   exp_t cur;
   bit   active = 1'b0;
   int   tcount = 0;
   logic oe_prev = 1'b0;
   always @(negedge clk) begin
      if (uart_oe && !oe_prev) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R11", "unexpected frame start", 1, 0);
            active = 1'b0;
         end else begin
            cur = exp_q.pop_front();
            active = 1'b1;
         end
         tcount = 0;
      end
      if (!uart_oe && oe_prev && active) begin
         chk(tcount == TPB * cur.len, "R2", "frame length in ticks", tcount, TPB * cur.len);
         chk(tx_done == 1'b1, "R7", "flag at frame end", int'(tx_done), 1);
         active = 1'b0;
      end
      if (uart_oe && baud_tick) begin
         tcount++;
         if (active && ((tcount - 1) % TPB == TPB / 2 - 1)) begin
            chk(txd == cur.bits[(tcount - 1) / TPB], "R3", "frame bit value",
                int'(txd), int'(cur.bits[(tcount - 1) / TPB]));
         end
      end
      oe_prev = uart_oe;
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state, R6 pass-through while idle
      @(negedge clk);
      chk(uart_oe == 0, "R1", "oe after reset", int'(uart_oe), 0);
      chk(tx_done == 0, "R1", "flag after reset", int'(tx_done), 0);
      chk(bit9_q == 0, "R1", "bit9 after reset", int'(bit9_q), 0);
      chk(irq == 0, "R1", "irq after reset", int'(irq), 0);
      chk(txd == 1, "R6", "idle pin follows port 1", int'(txd), 1);
      port_dout = 1'b0;
      @(negedge clk);
      chk(txd == 0, "R6", "idle pin follows port 0", int'(txd), 0);
      port_dout = 1'b1;

      // R2/R3 short frame, no parity
      send_char(8'hA5);
      @(negedge clk);
      chk(uart_oe == 1, "R2", "oe after write", int'(uart_oe), 1);
      chk(txd == 0, "R2", "start bit", int'(txd), 0);
      port_dout = 1'b0;
      @(negedge clk);
      chk(txd == 0, "R6", "pin owned during frame", int'(txd), 0);
      wait_idle();
      chk(txd == 0, "R6", "pin back to port", int'(txd), 0);
      port_dout = 1'b1;
      chk(irq == 0, "R10", "irq masked", int'(irq), 0);
      irq_en = 1'b1;
      @(negedge clk);
      chk(irq == 1, "R10", "irq enabled", int'(irq), 1);

      // R8 accepted write clears the flag
      send_char(8'h3C);
      @(negedge clk);
      chk(tx_done == 0, "R8", "flag cleared by write", int'(tx_done), 1'b0);
      chk(irq == 0, "R10", "irq follows flag", int'(irq), 0);
      wait_idle();

      // R4 automatic even parity in short frame
      par_en = 1'b1;
      send_char(8'h83);
      wait_idle();
      send_char(8'h07);
      wait_idle();
      par_en = 1'b0;

      // R8 software clear, R9 software set
      ctl_write(1'b0, 1'b0);
      @(negedge clk);
      chk(tx_done == 0, "R8", "software clear", int'(tx_done), 0);
      ctl_write(1'b1, 1'b0);
      @(negedge clk);
      chk(tx_done == 1, "R9", "software set", int'(tx_done), 1);
      chk(uart_oe == 0, "R9", "no frame on software set", int'(uart_oe), 0);
      chk(irq == 1, "R10", "irq on software set", int'(irq), 1);
      irq_en = 1'b0;

      // R5 ninth bit in long frames, sticky across frames; R4 parity ignored
      frame11 = 1'b1;
      ctl_write(1'b0, 1'b1);
      @(negedge clk);
      chk(bit9_q == 1, "R5", "bit9 loaded", int'(bit9_q), 1);
      send_char(8'h55);
      wait_idle();
      par_en = 1'b1;
      send_char(8'hAA);
      wait_idle();
      par_en = 1'b0;
      chk(bit9_q == 1, "R5", "bit9 kept after frames", int'(bit9_q), 1);

      // R5 receiver overwrite, and control write priority
      @(posedge clk); #1;
      rx_b9_load = 1'b1; rx_b9_value = 1'b0;
      @(posedge clk); #1;
      rx_b9_load = 1'b0;
      b9_model = 1'b0;
      @(negedge clk);
      chk(bit9_q == 0, "R5", "bit9 from receiver", int'(bit9_q), 0);
      send_char(8'hF0);
      wait_idle();
      @(posedge clk); #1;
      rx_b9_load = 1'b1; rx_b9_value = 1'b0;
      ctl_wr = 1'b1; ctl_done_wdata = 1'b0; ctl_b9_wdata = 1'b1;
      b9_model = 1'b1;
      @(posedge clk); #1;
      rx_b9_load = 1'b0; ctl_wr = 1'b0;
      @(negedge clk);
      chk(bit9_q == 1, "R5", "control write wins", int'(bit9_q), 1);

      // R11 write during a frame is ignored
      send_char(8'h1E);
      repeat (40) @(posedge clk);
      #1;
      dat_wr = 1'b1; dat_wdata = 8'hFF;
      @(posedge clk); #1;
      dat_wr = 1'b0;
      wait_idle();
      repeat (60) @(negedge clk);
      chk(uart_oe == 0, "R11", "no second frame", int'(uart_oe), 0);
      chk(exp_q.size() == 0, "R11", "scoreboard drained", exp_q.size(), 0);
      chk(tx_done == 1, "R11", "flag kept after ignored write", int'(tx_done), 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule